// File: doc/BRIEF.md
# Byte-Gathering String Loader with Stop Byte

This unit reads a run of bytes, one at a time, from a byte-wide memory port and scatters them into consecutive entries of a 32-entry register file. Each byte lands in one byte lane of the current register, and the register file keeps the other three lanes as they were. The run stops at a programmed byte count or earlier: a byte equal to a programmed stop value is still stored, and then the run ends. When the run ends, the unit reports how many bytes came before the stop byte. If no stop byte was found, it reports the full count.

A caller pulses `start` with the start address, a 7-bit byte count, the stop byte, the first target register and two register indices whose contents must be preserved. The base index only preserves a register when it is nonzero. The index register is always preserved. Bytes aimed at a preserved register are still fetched, but they are not written.

Memory requests, memory responses and register writes are valid/ready streams. A producer holds valid and its payload steady until ready is seen at a clock edge, and the transfer takes place on the edge where both are high. The unit accepts one memory response per request and issues at most one request at a time. It never drops a register write: the write stays presented until `rf_wr_ready` is high.

Top module: `lscb_unit`

## Requirements
- R1: The first byte goes to lane bits 31:24 of the first register. Later bytes go to bits 23:16, 15:8 and 7:0 in turn. Byte enable bit 3 selects bits 31:24 and bit 0 selects bits 7:0.
- R2: After the lane at bits 7:0, filling restarts at bits 31:24 of the next register. The register index counts modulo 32, so register 31 is followed by register 0.
- R3: Every register write carries exactly one byte-enable bit. The byte sits in that lane of `rf_wr_data`, and all other data bits are zero.
- R4: A byte aimed at the index register, or at a nonzero base register, is fetched from memory but produces no register write. The lane and register sequence still advances past it.
- R5: A fetched byte equal to the stop value is still written to its lane, unless its register is preserved. No further byte is fetched after it.
- R6: `done_count` equals the zero-based position of the stop byte when one is found. Otherwise it equals the byte count.
- R7: The memory address rises by one per byte. In 32-bit mode (`mode32` high), the upper 32 address bits are held at zero, both at the start and after each step, so the address wraps from 0xFFFFFFFF to 0.
- R8: A byte count of zero raises `done` on the cycle after the start is accepted, with `done_count` zero and no memory request.
- R9: An unaccepted memory request keeps its valid and address. An unaccepted register write keeps its valid, index, data and enables.
- R10: After reset `busy` and `done` are low. A start is taken only while `busy` is low. `done` is a single-cycle pulse that ends the busy period, and a start seen while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run when busy is low |
| start_addr | input | ADDR_W | Address of the first byte |
| byte_count | input | CNT_W | Number of bytes to load |
| cmp_byte | input | 8 | Stop byte value |
| first_reg | input | REG_W | Register that receives the first byte |
| base_reg | input | REG_W | Preserved register when nonzero |
| index_reg | input | REG_W | Always-preserved register |
| mode32 | input | 1 | 32-bit address wrap mode |
| busy | output | 1 | Run in progress, including the done cycle |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | ADDR_W | Byte address of request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Unit accepts read data |
| mem_rsp_data | input | 8 | Read byte |
| rf_wr_valid | output | 1 | Register write valid |
| rf_wr_ready | input | 1 | Register file accepts write |
| rf_wr_idx | output | REG_W | Register written |
| rf_wr_data | output | DATA_W | Byte placed in its lane, zeros elsewhere |
| rf_wr_be | output | DATA_W/8 | One-hot lane enable |
| done | output | 1 | One-cycle end-of-run pulse |
| done_count | output | CNT_W | Bytes before the stop byte, or the count |

## Verification
The stop-byte match and the exhaustion of the byte count can happen on the same byte. When the final byte of the run equals the stop value, the result must be the match position (count minus one), not the count. The sweep provokes this by placing the stop byte at every position from zero to one past the end, which includes the last position, and judges each run by its returned count and by the number of memory reads. A second overlap sweeps preserved registers so that they coincide with the matching byte's register. In that case the match must still end the run while the write is suppressed, and the bench judges it from the final register-file image.

// File: rtl/lscb_pkg.sv
package lscb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RSP,
    ST_WR,
    ST_DONE
  } lscb_state_e;
endpackage

// File: rtl/lscb_addr_gen.sv
module lscb_addr_gen #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              mode32,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(64'hFFFF_FFFF);

  logic [ADDR_W-1:0] addr_q;
  logic              narrow_q;
  logic [ADDR_W-1:0] load_val;
  logic [ADDR_W-1:0] step_val;

  always_comb begin
    load_val = mode32 ? (start_addr & LOW_MASK) : start_addr;
    step_val = addr_q + ADDR_W'(1);
    if (narrow_q) step_val = step_val & LOW_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      narrow_q <= 1'b0;
    end else if (load) begin
      addr_q   <= load_val;
      narrow_q <= mode32;
    end else if (step) begin
      addr_q   <= step_val;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/lscb_lane_seq.sv
module lscb_lane_seq #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                step,
  input  logic [REG_W-1:0]    first_reg,
  input  logic [7:0]          byte_in,
  output logic [REG_W-1:0]    reg_idx,
  output logic [DATA_W/8-1:0] lane_be,
  output logic [DATA_W-1:0]   lane_data
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  logic [REG_W-1:0]  reg_q;
  logic [LANE_W-1:0] lane_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q  <= '0;
      lane_q <= '0;
    end else if (load) begin
      reg_q  <= first_reg;
      lane_q <= '0;
    end else if (step) begin
      if (lane_q == LAST_LANE) begin
        lane_q <= '0;
        reg_q  <= reg_q + REG_W'(1);
      end else begin
        lane_q <= lane_q + LANE_W'(1);
      end
    end
  end

  // lane position 0 is the most significant byte
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_be[LANES-1-g]              = (lane_q == LANE_W'(g));
    assign lane_data[8*(LANES-1-g) +: 8]   = (lane_q == LANE_W'(g)) ? byte_in : 8'h00;
  end

  assign reg_idx = reg_q;
endmodule

// File: rtl/lscb_ctrl.sv
module lscb_ctrl
  import lscb_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [7:0]       cmp_byte,
  input  logic [REG_W-1:0] base_reg,
  input  logic [REG_W-1:0] index_reg,
  input  logic [REG_W-1:0] cur_reg,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic [7:0]       mem_rsp_data,
  input  logic             rf_wr_ready,
  output logic             busy,
  output logic             mem_req_valid,
  output logic             mem_rsp_ready,
  output logic             rf_wr_valid,
  output logic [7:0]       byte_out,
  output logic             load,
  output logic             step,
  output logic             done,
  output logic [CNT_W-1:0] done_count
);
  lscb_state_e      state_q;
  logic [CNT_W-1:0] total_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       cmp_q;
  logic [7:0]       byte_q;
  logic [REG_W-1:0] base_q;
  logic [REG_W-1:0] index_q;

  logic guarded;
  logic wr_go;
  logic hit;
  logic last;

  always_comb begin
    guarded = (cur_reg == index_q) || ((base_q != '0) && (cur_reg == base_q));
    wr_go   = (state_q == ST_WR) && (guarded || rf_wr_ready);
    hit     = (byte_q == cmp_q);
    last    = ((cnt_q + CNT_W'(1)) == total_q);
    load    = (state_q == ST_IDLE) && start;
    step    = wr_go && !hit && !last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      total_q <= '0;
      cnt_q   <= '0;
      cmp_q   <= '0;
      byte_q  <= '0;
      base_q  <= '0;
      index_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          total_q <= byte_count;
          cmp_q   <= cmp_byte;
          base_q  <= base_reg;
          index_q <= index_reg;
          cnt_q   <= '0;
          state_q <= (byte_count == '0) ? ST_DONE : ST_REQ;
        end
        ST_REQ: if (mem_req_ready) state_q <= ST_RSP;
        ST_RSP: if (mem_rsp_valid) begin
          byte_q  <= mem_rsp_data;
          state_q <= ST_WR;
        end
        ST_WR: if (wr_go) begin
          if (hit) begin
            state_q <= ST_DONE;
          end else begin
            cnt_q   <= cnt_q + CNT_W'(1);
            state_q <= last ? ST_DONE : ST_REQ;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_rsp_ready = (state_q == ST_RSP);
  assign rf_wr_valid   = (state_q == ST_WR) && !guarded;
  assign done          = (state_q == ST_DONE);
  assign done_count    = cnt_q;
  assign byte_out      = byte_q;
endmodule

// File: rtl/lscb_unit.sv
module lscb_unit #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int CNT_W  = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   start_addr,
  input  logic [CNT_W-1:0]    byte_count,
  input  logic [7:0]          cmp_byte,
  input  logic [REG_W-1:0]    first_reg,
  input  logic [REG_W-1:0]    base_reg,
  input  logic [REG_W-1:0]    index_reg,
  input  logic                mode32,
  output logic                busy,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [ADDR_W-1:0]   mem_req_addr,
  input  logic                mem_rsp_valid,
  output logic                mem_rsp_ready,
  input  logic [7:0]          mem_rsp_data,
  output logic                rf_wr_valid,
  input  logic                rf_wr_ready,
  output logic [REG_W-1:0]    rf_wr_idx,
  output logic [DATA_W-1:0]   rf_wr_data,
  output logic [DATA_W/8-1:0] rf_wr_be,
  output logic                done,
  output logic [CNT_W-1:0]    done_count
);
  logic             load;
  logic             step;
  logic [7:0]       cur_byte;
  logic [REG_W-1:0] cur_reg;

  lscb_ctrl #(.CNT_W(CNT_W), .REG_W(REG_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .byte_count    (byte_count),
    .cmp_byte      (cmp_byte),
    .base_reg      (base_reg),
    .index_reg     (index_reg),
    .cur_reg       (cur_reg),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .rf_wr_ready   (rf_wr_ready),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .rf_wr_valid   (rf_wr_valid),
    .byte_out      (cur_byte),
    .load          (load),
    .step          (step),
    .done          (done),
    .done_count    (done_count)
  );

  lscb_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .step       (step),
    .mode32     (mode32),
    .start_addr (start_addr),
    .addr       (mem_req_addr)
  );

  lscb_lane_seq #(.DATA_W(DATA_W), .REG_W(REG_W)) u_lane (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .first_reg (first_reg),
    .byte_in   (cur_byte),
    .reg_idx   (cur_reg),
    .lane_be   (rf_wr_be),
    .lane_data (rf_wr_data)
  );

  assign rf_wr_idx = cur_reg;
endmodule

// File: rtl/lscb_checker.sv
module lscb_checker #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int CNT_W  = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [ADDR_W-1:0]   start_addr,
  input logic [CNT_W-1:0]    byte_count,
  input logic [REG_W-1:0]    base_reg,
  input logic [REG_W-1:0]    index_reg,
  input logic                mode32,
  input logic                busy,
  input logic                mem_req_valid,
  input logic                mem_req_ready,
  input logic [ADDR_W-1:0]   mem_req_addr,
  input logic                rf_wr_valid,
  input logic                rf_wr_ready,
  input logic [REG_W-1:0]    rf_wr_idx,
  input logic [DATA_W-1:0]   rf_wr_data,
  input logic [DATA_W/8-1:0] rf_wr_be,
  input logic                done,
  input logic [CNT_W-1:0]    done_count
);
  localparam int LANES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(64'hFFFF_FFFF);

  logic [CNT_W-1:0]  total_c;
  logic [REG_W-1:0]  base_c;
  logic [REG_W-1:0]  index_c;
  logic              narrow_c;
  logic [ADDR_W-1:0] prev_addr;
  logic              have_prev;
  logic [ADDR_W-1:0] next_addr;
  logic [DATA_W-1:0] lane_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_c   <= '0;
      base_c    <= '0;
      index_c   <= '0;
      narrow_c  <= 1'b0;
      prev_addr <= '0;
      have_prev <= 1'b0;
    end else if (start && !busy) begin
      total_c   <= byte_count;
      base_c    <= base_reg;
      index_c   <= index_reg;
      narrow_c  <= mode32;
      have_prev <= 1'b0;
      prev_addr <= start_addr;
    end else if (mem_req_valid && mem_req_ready) begin
      prev_addr <= mem_req_addr;
      have_prev <= 1'b1;
    end
  end

  always_comb begin
    next_addr = prev_addr + ADDR_W'(1);
    if (narrow_c) next_addr = next_addr & LOW_MASK;
    for (int i = 0; i < LANES; i++) lane_mask[8*i +: 8] = {8{rf_wr_be[i]}};
  end

  p_onehot_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_valid |-> ($countones(rf_wr_be) == 1));

  p_clean_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_valid |-> ((rf_wr_data & ~lane_mask) == '0));

  p_no_guarded_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_valid |-> ((rf_wr_idx != index_c) && !((base_c != '0) && (rf_wr_idx == base_c))));

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_count <= total_c));

  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && have_prev) |-> (mem_req_addr == next_addr));

  p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (byte_count == '0)) |=> (done && (done_count == '0) && !mem_req_valid));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr_valid && !rf_wr_ready) |=>
      (rf_wr_valid && $stable(rf_wr_idx) && $stable(rf_wr_data) && $stable(rf_wr_be)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind lscb_unit lscb_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W), .CNT_W(CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .start_addr    (start_addr),
  .byte_count    (byte_count),
  .base_reg      (base_reg),
  .index_reg     (index_reg),
  .mode32        (mode32),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .rf_wr_valid   (rf_wr_valid),
  .rf_wr_ready   (rf_wr_ready),
  .rf_wr_idx     (rf_wr_idx),
  .rf_wr_data    (rf_wr_data),
  .rf_wr_be      (rf_wr_be),
  .done          (done),
  .done_count    (done_count)
);

// File: tb/lscb_unit_tb_top.sv
`timescale 1ns/1ps
module lscb_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] start_addr = '0;
  logic [6:0]  byte_count = '0;
  logic [7:0]  cmp_byte = '0;
  logic [4:0]  first_reg = '0, base_reg = '0, index_reg = '0;
  logic        mode32 = 1'b0;
  logic        busy, mem_req_valid, mem_rsp_ready, rf_wr_valid, done;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, rf_wr_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic [7:0]  mem_rsp_data = '0;
  logic [4:0]  rf_wr_idx;
  logic [31:0] rf_wr_data;
  logic [3:0]  rf_wr_be;
  logic [6:0]  done_count;

  always #10 clk = ~clk;

  lscb_unit dut_i (.*);

  int checks = 0, failures = 0;
  logic [31:0] rf_act [32];
  logic [31:0] rf_exp [32];
  logic [15:0] lfsr = 16'hACE1;
  bit          fast = 1'b0;
  bit          pend = 1'b0;
  logic [63:0] pend_addr = '0;
  int          nreads = 0, nwrites = 0, addr_bad = 0;
  logic [63:0] run_sa = '0;
  bit          run_m32 = 1'b0;

  function automatic logic [7:0] memf(logic [63:0] a);
    return a[7:0] + 8'h11;
  endfunction

  function automatic logic [63:0] addr_at(logic [63:0] s, int k, bit m32);
    if (m32) return {32'h0, s[31:0] + 32'(k)};
    return s + 64'(k);
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // observe handshakes
  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_addr != addr_at(run_sa, nreads, run_m32)) addr_bad++;
      nreads++;
      pend = 1'b1;
      pend_addr = mem_req_addr;
    end else if (mem_rsp_valid && mem_rsp_ready) begin
      pend = 1'b0;
    end
    if (rf_wr_valid && rf_wr_ready) begin
      for (int b = 0; b < 4; b++)
        if (rf_wr_be[b]) rf_act[rf_wr_idx][8*b +: 8] = rf_wr_data[8*b +: 8];
      nwrites++;
    end
  end

  // memory and register-file responders
  initial begin
    forever begin
      @(negedge clk);
      mem_req_ready = fast | lfsr[0];
      mem_rsp_valid = pend & (fast | lfsr[3]);
      mem_rsp_data  = memf(pend_addr);
      rf_wr_ready   = fast | lfsr[7];
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic run(logic [63:0] sa, int n, logic [7:0] cmp, logic [4:0] fr,
                     logic [4:0] br, logic [4:0] ir, bit m32, bit poke);
    int cnt_e = n, reads_e = 0, writes_e = 0;
    bit first_done;
    for (int r = 0; r < 32; r++) begin
      rf_act[r] = {8'hA5, 3'b0, 5'(r), 8'h3C, 8'(r * 9)};
      rf_exp[r] = rf_act[r];
    end
    for (int k = 0; k < n; k++) begin
      logic [4:0] rr = 5'(int'(fr) + k / 4);
      int lane = k % 4;
      logic [7:0] b = memf(addr_at(sa, k, m32));
      reads_e++;
      if (!(rr == ir || (br != 0 && rr == br))) begin
        rf_exp[rr][8*(3-lane) +: 8] = b;
        writes_e++;
      end
      if (b == cmp) begin cnt_e = k; break; end
    end
    nreads = 0; nwrites = 0; addr_bad = 0;
    run_sa = sa; run_m32 = m32;
    @(negedge clk);
    start = 1'b1; start_addr = sa; byte_count = 7'(n); cmp_byte = cmp;
    first_reg = fr; base_reg = br; index_reg = ir; mode32 = m32;
    @(negedge clk);
    start = 1'b0;
    first_done = done;
    if (poke) begin
      start = 1'b1; byte_count = 7'd5; first_reg = 5'd7; cmp_byte = 8'h00;
      start_addr = 64'h9000; base_reg = 5'd0; index_reg = 5'd0;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    if (n == 0) chk(first_done, "R8 done one cycle after start", 64'(first_done), 1);
    chk(done_count == 7'(cnt_e), "R6 returned count (R5 stop)", 64'(done_count), 64'(cnt_e));
    @(negedge clk);
    chk(!done && !busy, "R10 done pulse then idle", 64'({done, busy}), 0);
    chk(nreads == reads_e, "R5 R4 R8 memory reads", 64'(nreads), 64'(reads_e));
    chk(nwrites == writes_e, "R4 register writes", 64'(nwrites), 64'(writes_e));
    chk(addr_bad == 0, "R7 address sequence", 64'(addr_bad), 0);
    for (int r = 0; r < 32; r++)
      if (rf_act[r] !== rf_exp[r])
        chk(1'b0, $sformatf("R1 R2 R3 lane image reg %0d", r), 64'(rf_act[r]), 64'(rf_exp[r]));
    chk(1'b1, "R1 R2 R3 image compared", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req_valid && !rf_wr_valid, "R10 reset state",
        64'({busy, done, mem_req_valid, rf_wr_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R10 idle after reset", 64'({busy, done}), 0);
    // sweep count and stop position; m == n means no stop byte inside the run
    for (int n = 0; n <= 9; n++) begin
      for (int m = 0; m <= n; m++) begin
        logic [63:0] sa = 64'h1000 + 64'(n * 37 + m);
        logic [4:0]  fr = 5'(n * 7 + m * 3 + 26);
        logic [4:0]  br, ir;
        case (m % 3)
          0: begin ir = fr; br = 5'd0; end
          1: begin br = 5'(fr + 1); ir = 5'd20; end
          default: begin br = 5'd0; ir = 5'd0; end
        endcase
        fast = ((n + m) % 2) == 0;
        run(sa, n, memf(addr_at(sa, m, 1'b0)), fr, br, ir, 1'b0, 1'b0);
      end
    end
    fast = 1'b0;
    // stop byte on the final byte lands in a guarded register
    run(64'h2200, 6, memf(64'h2205), 5'd3, 5'd4, 5'd9, 1'b0, 1'b0);
    // 32-bit wrap versus 64-bit carry
    run(64'h5_FFFF_FFFD, 8, memf(64'h5), 5'd30, 5'd0, 5'd2, 1'b1, 1'b0);
    run(64'h5_FFFF_FFFD, 8, memf(64'h6_0000_0005), 5'd30, 5'd0, 5'd2, 1'b0, 1'b0);
    // maximal count across register 31 to 0, no stop byte
    run(64'h300, 127, memf(64'h300 + 64'd127), 5'd31, 5'd0, 5'd17, 1'b0, 1'b0);
    // start while busy must be ignored
    run(64'h4000, 9, memf(64'h4000 + 64'd9), 5'd12, 5'd13, 5'd0, 1'b0, 1'b1);
    fast = 1'b1;
    run(64'h4400, 0, 8'h00, 5'd1, 5'd0, 5'd0, 1'b0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule